// File: doc/BRIEF.md
# Locked Fractional Backlight PWM Generator

This block drives a backlight pulse-width-modulated output. A free-running counter sets the period. Its length comes from a programmable period value and a bit-count field. The output is high for the first part of each period. The length of that high part comes from a 16-bit duty field whose top bit-count bits form the integer high time. When fractional mode is on, the remaining low bits add one extra high cycle on a share of the periods. An accumulator paces those extra cycles.

Software writes duty and period settings through a small register write port. These writes always land in shadow copies. The live settings that drive the counter change only at a period rollover, and only while the group lock is clear. An update-pending status bit stays high from a shadow write until that copy has been made. The usual sequence is to set the lock, write both words, then clear the lock.

A registered converter is also included. It turns a 17-bit brightness level in 1.16 fixed point into the 16-bit active duty code for the live period setting, with rounding. Software then writes that code into the duty field.

Top module: `bl_pwm_gen`

## Requirements
- R1: Reset loads a duty control word of 0xC000FA00 and a period word of 0x000C0FA0 into both the shadow and the live settings. The lock and the update-pending bit are 0. The duty code valid strobe is 0. With these settings the output stays high continuously.
- R2: Register addresses are as follows. Address 0 is duty control: bit 31 is enable, bit 30 is fractional mode, bits 15:0 are the duty field. Address 1 is the period word: bits 20:16 are the bit count, bits 15:0 are the period value. Address 2 is the lock, in bit 0. Writes to address 3 are ignored.
- R3: A bit count of 0, or any value above 16, means 16. The period value is masked to its low bit-count bits. A masked period of 0 gives a period of 65535 cycles.
- R4: With fractional mode off, each period lasts exactly the masked period in cycles. The output is high while the counter, which starts at 0, is below duty >> (16 − bitcount).
- R5: With fractional mode on, let f = duty mod 2^(16−bitcount). Any 2^(16−bitcount) consecutive periods, counted from the second period after a load onward, hold exactly f extra high cycles beyond the integer high time. With fractional mode off, the low duty bits have no effect.
- R6: While the live enable bit is 0, the output is low.
- R7: A write to address 0 or 1 sets update-pending. While the lock is 1, update-pending stays 1, and the live settings and the output pattern do not change.
- R8: While the lock is 0 and update-pending is 1, the shadow settings are copied to the live settings at the next period rollover. Update-pending reads 0 from the cycle after the copy, and that cycle is counter value 0 of the new settings.
- R9: When the level valid input is high, one cycle later the valid strobe is high and the code output equals ((level × P) >> n) mod 2^16, plus bit (n − 1) of the product, also kept to 16 bits. Here n is the effective bit count and P is the live masked period, where a masked period of 0 stays 0. A level of 0x10000 therefore gives P << (16 − n). With the level valid input low, the strobe is low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 32 | Register write data |
| levelIn | input | 17 | Brightness level, 1.16 unsigned fixed point |
| levelValid | input | 1 | Level input valid |
| dutyCode | output | 16 | Converted active duty code |
| dutyCodeValid | output | 1 | Converted code valid, one cycle after the level |
| pwmOut | output | 1 | Backlight PWM output |
| updatePending | output | 1 | Shadow settings not yet live |
| lockState | output | 1 | Current group lock bit |

## Verification
A wrong counter limit or a wrong bit-count decode does not produce a single bad sample. It shows up as a wrong number of high cycles over a window of whole periods, so the bench counts highs over windows that are exact multiples of the expected period. A fault in the lock or pending logic shows up within one period: update-pending clears while locked, or the output pattern changes before the unlock. A fault in the fractional accumulator shows up only as a wrong total over a full cycle of 2^(16−bitcount) periods, and that is the window the bench measures. Converter faults appear one cycle after each level strobe.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int CNT_W   = 16;
  localparam int BC_W    = 5;
  localparam int LEVEL_W = CNT_W + 1;
  localparam int PROD_W  = LEVEL_W + CNT_W;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] ADDR_DUTY   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LOCK   = 2'd2;

  localparam logic [DATA_W-1:0] DUTY_RST   = 32'hC000_FA00;
  localparam logic [DATA_W-1:0] PERIOD_RST = 32'h000C_0FA0;

  typedef struct packed {
    logic             en;
    logic             frac;
    logic [CNT_W-1:0] duty;
    logic [BC_W-1:0]  bitCnt;
    logic [CNT_W-1:0] period;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
  } ctrl2dp_t;

  function automatic logic [BC_W-1:0] effBits(logic [BC_W-1:0] b);
    return (b == '0 || b > BC_W'(CNT_W)) ? BC_W'(CNT_W) : b;
  endfunction

  function automatic logic [CNT_W-1:0] maskPeriod(logic [CNT_W-1:0] p, logic [BC_W-1:0] b);
    return p & CNT_W'(({1'b0, {CNT_W{1'b0}}} + 1'b1 << b) - 1'b1);
  endfunction

  function automatic cfg_t cfgFromWords(logic [DATA_W-1:0] d, logic [DATA_W-1:0] p);
    cfg_t c;
    c.en     = d[31];
    c.frac   = d[30];
    c.duty   = d[CNT_W-1:0];
    c.bitCnt = p[CNT_W+BC_W-1:CNT_W];
    c.period = p[CNT_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/bl_pwm_ctrl.sv
module bl_pwm_ctrl
  import bl_pwm_pkg::*;
#(
  parameter logic [DATA_W-1:0] DUTY_INIT   = DUTY_RST,
  parameter logic [DATA_W-1:0] PERIOD_INIT = PERIOD_RST
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rollover,
  output cfg_t              liveCfg,
  output ctrl2dp_t          toDp,
  output logic              lockState,
  output logic              updatePending
);
  localparam cfg_t CFG_INIT = cfgFromWords(DUTY_INIT, PERIOD_INIT);

  cfg_t shCfg;
  logic dutyWr, periodWr, shadowWr, loadNow;
  logic unusedWr;

  assign unusedWr = ^wrData[29:CNT_W+BC_W];
  assign dutyWr   = wrEn && (wrAddr == ADDR_DUTY);
  assign periodWr = wrEn && (wrAddr == ADDR_PERIOD);
  assign shadowWr = dutyWr || periodWr;
  assign loadNow  = rollover && updatePending && !lockState;
  assign toDp.load = loadNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shCfg         <= CFG_INIT;
      liveCfg       <= CFG_INIT;
      lockState     <= 1'b0;
      updatePending <= 1'b0;
    end else begin
      if (dutyWr) begin
        shCfg.en   <= wrData[31];
        shCfg.frac <= wrData[30];
        shCfg.duty <= wrData[CNT_W-1:0];
      end
      if (periodWr) begin
        shCfg.bitCnt <= wrData[CNT_W+BC_W-1:CNT_W];
        shCfg.period <= wrData[CNT_W-1:0];
      end
      if (wrEn && wrAddr == ADDR_LOCK) lockState <= wrData[0];
      if (loadNow) liveCfg <= shCfg;
      if (shadowWr)     updatePending <= 1'b1;
      else if (loadNow) updatePending <= 1'b0;
    end
  end
endmodule

// File: rtl/bl_pwm_dp.sv
module bl_pwm_dp
  import bl_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  cfg_t     cfg,
  input  ctrl2dp_t strb,
  output logic     rollover,
  output logic     pwmOut
);
  logic [BC_W-1:0]  bits, fracBits;
  logic [CNT_W-1:0] perMasked, lastCnt, cnt, intDuty, fracMask, fracDuty, acc;
  logic [CNT_W:0]   accSum, highLen;
  logic             carry, extra;

  always_comb begin
    bits      = effBits(cfg.bitCnt);
    fracBits  = BC_W'(CNT_W) - bits;
    perMasked = maskPeriod(cfg.period, bits);
    lastCnt   = (perMasked == '0) ? {{(CNT_W-1){1'b1}}, 1'b0} : perMasked - 1'b1;
    intDuty   = cfg.duty >> fracBits;
    fracMask  = CNT_W'(({1'b0, {CNT_W{1'b0}}} + 1'b1 << fracBits) - 1'b1);
    fracDuty  = cfg.frac ? (cfg.duty & fracMask) : '0;
    accSum    = {1'b0, acc} + {1'b0, fracDuty};
    carry     = (fracBits != '0) && accSum[fracBits];
    rollover  = (cnt >= lastCnt);
    highLen   = {1'b0, intDuty} + {{CNT_W{1'b0}}, extra};
    pwmOut    = cfg.en && ({1'b0, cnt} < highLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      acc   <= '0;
      extra <= 1'b0;
    end else begin
      cnt <= rollover ? '0 : cnt + 1'b1;
      if (strb.load) begin
        acc   <= '0;
        extra <= 1'b0;
      end else if (rollover) begin
        acc   <= accSum[CNT_W-1:0] & fracMask;
        extra <= carry;
      end
    end
  end
endmodule

// File: rtl/bl_level_conv.sv
module bl_level_conv
  import bl_pwm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] levelIn,
  input  logic               levelValid,
  input  logic [BC_W-1:0]    bitCnt,
  input  logic [CNT_W-1:0]   period,
  output logic [CNT_W-1:0]   dutyCode,
  output logic               dutyCodeValid
);
  logic [BC_W-1:0]   bits;
  logic [5:0]        rIdx;
  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  result;

  always_comb begin
    bits   = effBits(bitCnt);
    rIdx   = {1'b0, bits} - 6'd1;
    prod   = PROD_W'(levelIn) * PROD_W'(maskPeriod(period, bits));
    result = CNT_W'(prod >> bits) + {{(CNT_W-1){1'b0}}, prod[rIdx]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dutyCode      <= '0;
      dutyCodeValid <= 1'b0;
    end else begin
      dutyCodeValid <= levelValid;
      if (levelValid) dutyCode <= result;
    end
  end
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
  import bl_pwm_pkg::*;
#(
  parameter logic [31:0] DUTY_INIT   = 32'hC000_FA00,
  parameter logic [31:0] PERIOD_INIT = 32'h000C_0FA0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [16:0] levelIn,
  input  logic        levelValid,
  output logic [15:0] dutyCode,
  output logic        dutyCodeValid,
  output logic        pwmOut,
  output logic        updatePending,
  output logic        lockState
);
  cfg_t     liveCfg;
  ctrl2dp_t toDp;
  logic     rollover;
  logic     liveEn, loadStb;

  assign liveEn  = liveCfg.en;
  assign loadStb = toDp.load;

  bl_pwm_ctrl #(.DUTY_INIT(DUTY_INIT), .PERIOD_INIT(PERIOD_INIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rollover(rollover), .liveCfg(liveCfg), .toDp(toDp),
    .lockState(lockState), .updatePending(updatePending)
  );

  bl_pwm_dp u_dp (
    .clk(clk), .rstN(rstN), .cfg(liveCfg), .strb(toDp),
    .rollover(rollover), .pwmOut(pwmOut)
  );

  bl_level_conv u_conv (
    .clk(clk), .rstN(rstN), .levelIn(levelIn), .levelValid(levelValid),
    .bitCnt(liveCfg.bitCnt), .period(liveCfg.period),
    .dutyCode(dutyCode), .dutyCodeValid(dutyCodeValid)
  );
endmodule

// File: rtl/bl_pwm_gen_chk.sv
module bl_pwm_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic       levelValid,
  input logic       dutyCodeValid,
  input logic       pwmOut,
  input logic       updatePending,
  input logic       lockState,
  input logic       liveEn,
  input logic       loadStb
);
  logic shadowWr;
  assign shadowWr = wrEn && (wrAddr == 2'd0 || wrAddr == 2'd1);

  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    shadowWr |=> updatePending);
  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockState && updatePending) |=> updatePending);
  // R8
  load_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> (!lockState && updatePending));
  // R8
  load_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !shadowWr) |=> !updatePending);
  // R6
  en_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !liveEn |-> !pwmOut);
  // R9
  conv_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    levelValid |=> dutyCodeValid);
  // R9
  conv_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !levelValid |=> !dutyCodeValid);
endmodule

bind bl_pwm_gen bl_pwm_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .levelValid(levelValid), .dutyCodeValid(dutyCodeValid), .pwmOut(pwmOut),
  .updatePending(updatePending), .lockState(lockState),
  .liveEn(liveEn), .loadStb(loadStb)
);

// File: tb/bl_pwm_gen_tb.sv
module bl_pwm_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [16:0] levelIn = '0;
  logic        levelValid = 1'b0;
  logic [15:0] dutyCode;
  logic        dutyCodeValid, pwmOut, updatePending, lockState;

  int checkCnt = 0;
  int failCnt = 0;
  int liveBits = 12;
  int livePer = 32'hFA0;

  always #2 clk = ~clk;

  bl_pwm_gen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .levelIn(levelIn), .levelValid(levelValid), .dutyCode(dutyCode),
    .dutyCodeValid(dutyCodeValid), .pwmOut(pwmOut),
    .updatePending(updatePending), .lockState(lockState)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int effB(int b);
    return (b == 0 || b > 16) ? 16 : b;
  endfunction

  function automatic logic [15:0] convExp(logic [16:0] lv, int b, int per);
    longint p;
    int n;
    n = effB(b);
    p = longint'(lv) * longint'(per & ((1 << n) - 1));
    return 16'((p >> n) + ((p >> (n - 1)) & 1));
  endfunction

  function automatic logic [31:0] dutyWord(bit en, bit fr, logic [15:0] d);
    return {en, fr, 14'd0, d};
  endfunction

  function automatic logic [31:0] perWord(int b, int per);
    return {11'd0, 5'(b), 16'(per)};
  endfunction

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitLoad(output int waited);
    waited = 0;
    while (updatePending) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic configure(input logic [31:0] dw, input logic [31:0] pw);
    int w;
    writeReg(2'd2, 32'd1);
    writeReg(2'd1, pw);
    writeReg(2'd0, dw);
    writeReg(2'd2, 32'd0);
    waitLoad(w);
    liveBits = int'(pw[20:16]);
    livePer  = int'(pw[15:0]);
  endtask

  task automatic measureHigh(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (pwmOut) highs++;
      @(negedge clk);
    end
  endtask

  task automatic convCheck(input logic [16:0] lv);
    logic [15:0] exp;
    exp = convExp(lv, liveBits, livePer);
    @(negedge clk);
    levelIn = lv; levelValid = 1'b1;
    @(negedge clk);
    levelValid = 1'b0;
    check(dutyCodeValid === 1'b1, "R9 valid strobe", dutyCodeValid, 1);
    check(dutyCode === exp, "R9 code", dutyCode, exp);
    @(negedge clk);
    check(dutyCodeValid === 1'b0, "R9 strobe idle", dutyCodeValid, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    int h, w, b, per, iv, fr, fb;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(updatePending === 1'b0, "R1 pending", updatePending, 0);
    check(lockState === 1'b0, "R1 lock", lockState, 0);
    check(dutyCodeValid === 1'b0, "R1 valid", dutyCodeValid, 0);
    measureHigh(200, h);
    check(h == 200, "R1 full duty", h, 200);
    convCheck(17'h10000); // R9 max level on reset period: 0xFA00

    // R3 masking of period to bit count, R4 integer duty
    configure(dutyWord(1, 0, 16'h3000), perWord(4, 16'h0FF6));
    measureHigh(30, h);
    check(h == 15, "R3 masked period", h, 15);
    // R5 fraction bits ignored when fractional mode is off
    configure(dutyWord(1, 0, 16'h3FFF), perWord(4, 6));
    measureHigh(30, h);
    check(h == 15, "R5 frac off", h, 15);
    // R3 bit count 0 and above 16 mean 16
    configure(dutyWord(1, 0, 16'h000A), perWord(0, 20));
    measureHigh(60, h);
    check(h == 30, "R3 bitcount zero", h, 30);
    configure(dutyWord(1, 0, 16'h0007), perWord(20, 20));
    measureHigh(40, h);
    check(h == 14, "R3 bitcount over 16", h, 14);
    // R2 address 3 ignored
    writeReg(2'd3, 32'hFFFF_FFFF);
    check(updatePending === 1'b0 && lockState === 1'b0, "R2 addr3", {updatePending, lockState}, 0);
    measureHigh(40, h);
    check(h == 14, "R2 addr3 no effect", h, 14);

    // R4 random integer duty
    for (int k = 0; k < 8; k++) begin
      b = $urandom_range(2, 8);
      per = $urandom_range(1, (1 << b) - 1);
      iv = $urandom_range(0, per);
      configure(dutyWord(1, 0, 16'((iv << (16 - b)) | ($urandom & ((1 << (16 - b)) - 1)))), perWord(b, per));
      measureHigh(4 * per, h);
      check(h == 4 * iv, "R4 random duty", h, 4 * iv);
    end

    // R5 fractional pacing over a full accumulator cycle
    for (int k = 0; k < 6; k++) begin
      b = 14; fb = 2;
      per = $urandom_range(3, 9);
      iv = $urandom_range(0, per - 1);
      fr = $urandom_range(0, 3);
      configure(dutyWord(1, 1, 16'((iv << fb) | fr)), perWord(b, per));
      measureHigh(per, h);
      measureHigh((1 << fb) * per, h);
      check(h == 4 * iv + fr, "R5 fractional", h, 4 * iv + fr);
    end

    // R9 random levels against the live period
    convCheck(17'h0EFF0);
    for (int k = 0; k < 6; k++) convCheck(17'($urandom));

    // R6 enable off
    configure(dutyWord(0, 0, 16'h0024), perWord(14, 9));
    measureHigh(27, h);
    check(h == 0, "R6 disabled", h, 0);

    // R7 lock holds shadow writes
    configure(dutyWord(1, 0, 16'h2000), perWord(4, 8));
    writeReg(2'd2, 32'd1);
    writeReg(2'd0, dutyWord(1, 0, 16'h6000));
    repeat (40) @(negedge clk);
    check(updatePending === 1'b1, "R7 pending held", updatePending, 1);
    measureHigh(24, h);
    check(h == 6, "R7 output unchanged", h, 6);
    // R8 unlock copies at next rollover
    writeReg(2'd2, 32'd0);
    waitLoad(w);
    check(w <= 8, "R8 copy within period", w, 8);
    measureHigh(16, h);
    check(h == 12, "R8 new duty live", h, 12);
    // R8 unlocked single write
    writeReg(2'd0, dutyWord(1, 0, 16'h4000));
    check(updatePending === 1'b1, "R8 pending set", updatePending, 1);
    waitLoad(w);
    check(w <= 8, "R8 unlocked copy", w, 8);
    measureHigh(16, h);
    check(h == 8, "R8 unlocked duty", h, 8);

    // R3 masked period 0 means 65535 cycles
    configure(dutyWord(1, 0, 16'h0003), perWord(16, 0));
    measureHigh(65535, h);
    check(h == 3, "R3 zero period highs", h, 3);
    check(pwmOut === 1'b1, "R3 zero period wrap", pwmOut, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule